// File: doc/BRIEF.md
# Synthesizer Loop Divider and Phase/Frequency Detector Core

This block is the digital heart of a frequency synthesizer loop. It runs on one fast sampling clock. Two strobe inputs each mark one cycle of a slower source: `xtal_tick` for the crystal and `osc_tick` for the tuned oscillator. A reference divider counts crystal strobes by one of four fixed ratios. A feedback divider counts oscillator strobes by a programmable 15-bit ratio. An edge-triggered phase/frequency detector then compares the falling edges of the two divided square waves.

The detector drives two pulse outputs, `pump_up` and `pump_dn`, which command an external charge pump, and a `pump_hiz` flag that is high whenever neither pulse is active. Test codes can force the pump idle, or bring both divided waves out on two port pins for bench measurement. A pump-current select bit passes straight through to the pump.

Top module: `pll_divdet_top`

## Requirements
- R1: The feedback ratio N is taken from `fb_ratio`. Any value below 256 is used as 256. The feedback divided signal has a period of N oscillator strobes and is high for the first N - floor(N/2) strobes after each reload.
- R2: `ref_sel` picks the reference ratio with this code: 0 gives 24, 1 gives 64, 2 gives 80, 3 gives 128. The reference divided signal has a period of that many crystal strobes.
- R3: A new `fb_ratio` or `ref_sel` value is loaded only when the divider's count reaches zero on a strobe. A change made between terminal counts does not shorten or lengthen the cycle in progress.
- R4: When the feedback divided signal falls before the reference divided signal, `pump_up` goes high on the clock edge after that fall and stays high until the clock edge after the reference fall. In the opposite order `pump_dn` behaves the same way.
- R5: `pump_up` and `pump_dn` are never high together. When both falls occur in the same cycle, neither output is asserted. `pump_hiz` is high exactly when neither pump output is high.
- R6: With `test_mode` = 3'b010, both pump outputs stay low and `pump_hiz` stays high regardless of phase.
- R7: With `test_mode` = 3'b100, `test_fb_out` carries the feedback divided signal and `test_ref_out` carries the reference divided signal. With any other code, both are low.
- R8: `cur_sel_out` always equals `cur_sel_in`.
- R9: After reset, the pump outputs are low, `pump_hiz` is high, both test outputs are low, and both dividers reload on their first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | One-cycle strobe per crystal period |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| fb_ratio | input | 15 | Feedback divide ratio |
| ref_sel | input | 2 | Reference ratio code |
| test_mode | input | 3 | Test code |
| cur_sel_in | input | 1 | Pump current select from control |
| pump_up | output | 1 | Source-current pulse |
| pump_dn | output | 1 | Sink-current pulse |
| pump_hiz | output | 1 | Pump idle (high impedance) |
| test_fb_out | output | 1 | Routed feedback divided signal |
| test_ref_out | output | 1 | Routed reference divided signal |
| cur_sel_out | output | 1 | Pump current select to pump |

## Verification
Two events can land in the same cycle. The first is the falling edge of the reference wave together with the falling edge of the feedback wave. The second is a ratio change together with the terminal count that loads it. The first case is provoked by starting both strobe streams on the same edge with equal divided periods. It is judged by requiring zero pump activity over many comparison periods. The second case is provoked by changing the ratio right after a divided-wave fall, and the next fall-to-fall interval is required to equal half the old ratio plus the upper part of the new one.

// File: rtl/pll_divdet_pkg.sv
`timescale 1ns/1ps
package pll_divdet_pkg;

    localparam logic [2:0] TM_FORCE_IDLE = 3'b010;
    localparam logic [2:0] TM_ROUTE_DIV  = 3'b100;

    // reference ratio per select code
    function automatic logic [7:0] ref_ratio_of(input logic [1:0] code);
        case (code)
            2'd0:    ref_ratio_of = 8'd24;
            2'd1:    ref_ratio_of = 8'd64;
            2'd2:    ref_ratio_of = 8'd80;
            default: ref_ratio_of = 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/pll_tick_div.sv
`timescale 1ns/1ps
module pll_tick_div #(
    parameter int W         = 15,
    parameter int MIN_RATIO = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         div_o,
    output logic         fall_o
);
    localparam logic [W-1:0] RST_ACT = W'(MIN_RATIO);
    localparam logic [W-1:0] ONE     = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] act;
        logic         prev;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    level;

    assign level  = (st_q.cnt >= (st_q.act >> 1));
    assign div_o  = level;
    assign fall_o = st_q.prev & ~level;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
        if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = ratio - ONE;
                st_d.act = ratio;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.act  <= RST_ACT;
            st_q.prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> $stable(st_q.act)); // R3
    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act >= RST_ACT); // R1
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.act); // R1

endmodule

// File: rtl/pll_pfd_core.sv
`timescale 1ns/1ps
module pll_pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_fall,
    input  logic ref_fall,
    output logic up_o,
    output logic dn_o
);
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;

    pfd_st_t st_d, st_q;
    logic    clear;

    assign clear = st_q.up & st_q.dn;
    assign up_o  = st_q.up;
    assign dn_o  = st_q.dn;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end else begin
            st_d.up = st_q.up | fb_fall;
            st_d.dn = st_q.dn | ref_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BOTH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.dn) |=> (!st_q.up && !st_q.dn)); // R5
    AST_UP_ON_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_fall && !clear) |=> st_q.up); // R4

endmodule

// File: rtl/pll_divdet_top.sv
`timescale 1ns/1ps
module pll_divdet_top #(
    parameter int FB_W   = 15,
    parameter int FB_MIN = 256,
    parameter int REF_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xtal_tick,
    input  logic            osc_tick,
    input  logic [FB_W-1:0] fb_ratio,
    input  logic [1:0]      ref_sel,
    input  logic [2:0]      test_mode,
    input  logic            cur_sel_in,
    output logic            pump_up,
    output logic            pump_dn,
    output logic            pump_hiz,
    output logic            test_fb_out,
    output logic            test_ref_out,
    output logic            cur_sel_out
);
    import pll_divdet_pkg::*;

    localparam logic [FB_W-1:0] FB_FLOOR = FB_W'(FB_MIN);

    logic [FB_W-1:0]  fb_eff;
    logic [REF_W-1:0] ref_eff;
    logic fb_div, fb_fall, ref_div, ref_fall;
    logic det_up, det_dn, idle_forced, route_on;

    assign fb_eff  = (fb_ratio < FB_FLOOR) ? FB_FLOOR : fb_ratio;
    assign ref_eff = REF_W'(ref_ratio_of(ref_sel));

    pll_tick_div #(.W(REF_W), .MIN_RATIO(24)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .tick(xtal_tick), .ratio(ref_eff),
        .div_o(ref_div), .fall_o(ref_fall)
    );

    pll_tick_div #(.W(FB_W), .MIN_RATIO(FB_MIN)) u_fb_div (
        .clk(clk), .rst_n(rst_n), .tick(osc_tick), .ratio(fb_eff),
        .div_o(fb_div), .fall_o(fb_fall)
    );

    pll_pfd_core u_pfd (
        .clk(clk), .rst_n(rst_n), .fb_fall(fb_fall), .ref_fall(ref_fall),
        .up_o(det_up), .dn_o(det_dn)
    );

    assign idle_forced  = (test_mode == TM_FORCE_IDLE);
    assign route_on     = (test_mode == TM_ROUTE_DIV);
    assign pump_up      = det_up & ~det_dn & ~idle_forced;
    assign pump_dn      = det_dn & ~det_up & ~idle_forced;
    assign pump_hiz     = ~(pump_up | pump_dn);
    assign test_fb_out  = route_on & fb_div;
    assign test_ref_out = route_on & ref_div;
    assign cur_sel_out  = cur_sel_in;

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn)); // R5
    AST_FORCED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == 3'b010) |-> (pump_hiz && !pump_up && !pump_dn)); // R6
    AST_ROUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode != 3'b100) |-> (!test_fb_out && !test_ref_out)); // R7
    AST_SEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        cur_sel_out == cur_sel_in); // R8

endmodule

// File: tb/sim_pll_divdet_top.sv
`timescale 1ns/1ps
module sim_pll_divdet_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_tick = 1'b0, osc_tick = 1'b0;
    logic [14:0] fb_ratio = 15'd256;
    logic [1:0]  ref_sel = 2'd1;
    logic [2:0]  test_mode = 3'b000;
    logic cur_sel_in = 1'b0;
    logic pump_up, pump_dn, pump_hiz, test_fb_out, test_ref_out, cur_sel_out;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pll_divdet_top u0 (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .osc_tick(osc_tick),
        .fb_ratio(fb_ratio), .ref_sel(ref_sel), .test_mode(test_mode),
        .cur_sel_in(cur_sel_in), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hiz(pump_hiz), .test_fb_out(test_fb_out),
        .test_ref_out(test_ref_out), .cur_sel_out(cur_sel_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_rc, m_ra, m_fc, m_fa;
    bit m_rp, m_fp, m_up, m_dn;

    function automatic int ref_of(input int code);
        int t[4] = '{24, 64, 80, 128};
        return t[code];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rc = 0; m_ra = 24; m_fc = 0; m_fa = 256;
            m_rp = 0; m_fp = 0; m_up = 0; m_dn = 0;
        end else begin
            bit rd, fd, rfall, ffall, nu, nd;
            rd = (m_rc >= m_ra / 2);
            fd = (m_fc >= m_fa / 2);
            ffall = m_fp && !fd;
            rfall = m_rp && !rd;
            nu = (m_up && m_dn) ? 1'b0 : (m_up || ffall);
            nd = (m_up && m_dn) ? 1'b0 : (m_dn || rfall);
            m_up = nu; m_dn = nd; m_fp = fd; m_rp = rd;
            if (xtal_tick) begin
                if (m_rc == 0) begin m_ra = ref_of(int'(ref_sel)); m_rc = m_ra - 1; end
                else m_rc--;
            end
            if (osc_tick) begin
                if (m_fc == 0) begin
                    m_fa = (int'(fb_ratio) < 256) ? 256 : int'(fb_ratio);
                    m_fc = m_fa - 1;
                end else m_fc--;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && !done) begin
                bit eu, ed, idle, route;
                idle  = (test_mode == 3'b010);
                route = (test_mode == 3'b100);
                eu = m_up && !m_dn && !idle;
                ed = m_dn && !m_up && !idle;
                chk("R4", "pump_up", pump_up, eu);
                chk("R4", "pump_dn", pump_dn, ed);
                chk("R5", "pump_hiz", pump_hiz, !(eu || ed));
                chk("R7", "test_fb_out", test_fb_out, route && (m_fc >= m_fa / 2));
                chk("R7", "test_ref_out", test_ref_out, route && (m_rc >= m_ra / 2));
                chk("R8", "cur_sel_out", cur_sel_out, cur_sel_in);
            end
        end
    end

    // strobe generators
    bit xt_on = 0, ot_on = 0;
    int xt_every = 1, ot_every = 1;
    initial begin
        int xc = 0, oc = 0;
        forever begin
            @(negedge clk);
            if (xt_on) begin xtal_tick = (xc % xt_every) == 0; xc++; end
            else begin xtal_tick = 0; xc = 0; end
            if (ot_on) begin osc_tick = (oc % ot_every) == 0; oc++; end
            else begin osc_tick = 0; oc = 0; end
        end
    end

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        xt_on = 0; ot_on = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // wait for a fall on a routed signal (sel 1 = feedback)
    task automatic wait_fall(input bit sel);
        bit p, c;
        p = sel ? test_fb_out : test_ref_out;
        for (int i = 0; i < 40000; i++) begin
            step;
            c = sel ? test_fb_out : test_ref_out;
            if (p && !c) return;
            p = c;
        end
    endtask

    task automatic meas(input bit sel, output int period, output int high);
        bit p, c;
        period = 0; high = 0;
        p = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            step;
            period++;
            c = sel ? test_fb_out : test_ref_out;
            if (c) high++;
            if (p && !c) return;
            p = c;
        end
    endtask

    task automatic run_count(input int n, output int ups, output int dns, output int hz);
        ups = 0; dns = 0; hz = 0;
        for (int i = 0; i < n; i++) begin
            step;
            if (pump_up) ups++;
            if (pump_dn) dns++;
            if (pump_hiz) hz++;
        end
    endtask

    initial begin
        int per, hi, ups, dns, hz;
        do_reset;
        step;
        // R9 reset state
        chk("R9", "reset pump_up", pump_up, 0);
        chk("R9", "reset pump_dn", pump_dn, 0);
        chk("R9", "reset pump_hiz", pump_hiz, 1);
        chk("R9", "reset test outs", test_fb_out | test_ref_out, 0);

        // R8 pass-through
        @(negedge clk); cur_sel_in = 1; step;
        chk("R8", "cur_sel high", cur_sel_out, 1);
        @(negedge clk); cur_sel_in = 0; step;
        chk("R8", "cur_sel low", cur_sel_out, 0);

        // R5 in phase: ref 64 every 4 cycles, feedback 256 every cycle, same start
        do_reset;
        @(negedge clk); ref_sel = 2'd1; fb_ratio = 15'd256; xt_every = 4; ot_every = 1;
        xt_on = 1; ot_on = 1;
        run_count(2000, ups, dns, hz);
        chk("R5", "in-phase up cycles", ups, 0);
        chk("R5", "in-phase dn cycles", dns, 0);

        // R4 feedback leads by 4 cycles
        do_reset;
        @(negedge clk); ot_on = 1;
        repeat (4) @(negedge clk);
        xt_on = 1;
        run_count(2000, ups, dns, hz);
        chk("R4", "fb-lead up seen", ups > 0, 1);
        chk("R4", "fb-lead dn cycles", dns, 0);

        // R4 reference leads
        do_reset;
        @(negedge clk); xt_on = 1;
        repeat (4) @(negedge clk);
        ot_on = 1;
        run_count(2000, ups, dns, hz);
        chk("R4", "ref-lead dn seen", dns > 0, 1);
        chk("R4", "ref-lead up cycles", ups, 0);

        // R6 forced idle with feedback leading
        do_reset;
        @(negedge clk); test_mode = 3'b010; ot_on = 1;
        repeat (4) @(negedge clk);
        xt_on = 1;
        run_count(2000, ups, dns, hz);
        chk("R6", "forced idle up", ups, 0);
        chk("R6", "forced idle hiz", hz, 2000);

        // R7 quiet test outputs when not routed, R1 / R2 periods when routed
        do_reset;
        @(negedge clk); test_mode = 3'b000; fb_ratio = 15'd300; ref_sel = 2'd2;
        xt_every = 1; ot_every = 1; xt_on = 1; ot_on = 1;
        hi = 0;
        for (int i = 0; i < 700; i++) begin
            step;
            if (test_fb_out || test_ref_out) hi++;
        end
        chk("R7", "unrouted test activity", hi, 0);
        @(negedge clk); test_mode = 3'b100;
        wait_fall(1'b1);
        meas(1'b1, per, hi);
        chk("R1", "fb period N=300", per, 300);
        chk("R1", "fb high time N=300", hi, 150);
        wait_fall(1'b0);
        meas(1'b0, per, hi);
        chk("R2", "ref period code 2", per, 80);
        @(negedge clk); ref_sel = 2'd0;
        wait_fall(1'b0); wait_fall(1'b0);
        meas(1'b0, per, hi);
        chk("R2", "ref period code 0", per, 24);

        // R3 ratio change mid-cycle: 300 -> 400 right after a fall
        wait_fall(1'b1);
        fb_ratio = 15'd400;
        meas(1'b1, per, hi);
        chk("R3", "transition interval", per, 350);
        meas(1'b1, per, hi);
        chk("R3", "new period", per, 400);

        // R1 clamp below floor
        @(negedge clk); fb_ratio = 15'd100;
        wait_fall(1'b1); wait_fall(1'b1);
        meas(1'b1, per, hi);
        chk("R1", "clamped period", per, 256);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule